// File: doc/BRIEF.md
# Pulse-Counting Pixel Array Readout

This block holds the digital half of an array of pulse-frequency-modulated pixels. Every pixel delivers a single-cycle self-reset strobe each time its integrator trips. While the integration window is open, each pixel counts those strobes in its own saturating counter. A write strobe then copies every count into a per-pixel frame word.

When the following integration window opens, a scanner walks the stored frame in row-major order and streams one word per cycle, tagged with its row and column. The new frame keeps counting underneath the scan. If a write strobe lands while a scan is still running, the block raises a sticky overrun flag.

An output stage can rescale each streamed code by one array-wide coefficient. The coefficient is the measured mean reset swing divided by the ideal swing, which is the flip level minus the reset level. It corrects the loss of linearity that comparator delay and limited amplifier bandwidth cause at large input currents.

Top module: `pfm_frame_readout`

## Requirements
- R1: The asynchronous reset rst_ni and the synchronous clear clr_i both return every control flag to its initial state: no stored frame pending, no scan, overrun_o low and pix_valid_o low. They also set every pixel counter to zero, and a strobe in the clear cycle is not counted.
- R2: A pixel counts a strobe on pulse_i only in a cycle where int_i is high. The counter restarts in the first cycle of each int_i window, and that cycle's strobe becomes its first count.
- R3: The counter saturates at 4095 and does not wrap.
- R4: wr_i copies each counter into its frame word. The copied value includes a strobe that arrives in the same cycle as wr_i while int_i is high.
- R5: A scan starts only on a rising edge of int_i after a write. It emits every pixel in row-major order from (0,0) on consecutive cycles, with row and column tags. The first word appears on pix_valid_o three clock edges after the edge that samples the rising int_i.
- R6: eof_o pulses for one cycle, in the cycle right after the word of the last pixel (ROWS-1, COLS-1).
- R7: overrun_o goes high when wr_i arrives during a scan or in the cycle a scan starts. It stays high until clr_i or reset.
- R8: With corr_en_i high, the code equals min(4095, floor((raw*gain_i + 8192) / 16384)). gain_i is unsigned with 14 fraction bits, so 16384 is a gain of 1.0.
- R9: With corr_en_i low, the streamed code equals the stored count, whatever the value of gain_i.
- R10: A rising int_i with no frame written since the last reset, clear or scan start produces no output words.
- R11: Counting for the new frame continues during a scan and does not disturb the words being streamed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous array clear |
| int_i | input | 1 | Integration window |
| wr_i | input | 1 | Frame store strobe |
| pulse_i | input | ROWS*COLS | Self-reset strobes, bit row*COLS+col |
| gain_i | input | 16 | Swing ratio coefficient, 14 fraction bits |
| corr_en_i | input | 1 | Enable gain correction |
| pix_valid_o | output | 1 | Output word valid |
| pix_row_o | output | clog2(ROWS) | Row index of word |
| pix_col_o | output | clog2(COLS) | Column index of word |
| pix_code_o | output | 12 | Streamed code |
| eof_o | output | 1 | End of frame pulse |
| overrun_o | output | 1 | Sticky write-during-scan flag |

## Verification
A self-reset strobe and the write strobe can land in the same cycle. The bench drives pulses on every pixel in the write cycle, and its count model includes them, so each streamed word shows whether the last strobe was taken. The write strobe can also collide with a running scan. The bench fires wr_i a few cycles after the scan starts and judges the result from overrun_o, from its persistence over the next frame, and from its release by clr_i.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int CNT_W_DEF  = 12;
  localparam int GAIN_W_DEF = 16;
  localparam int FRAC_DEF   = 14;
endpackage

// File: rtl/pfm_pixel_array.sv
module pfm_pixel_array #(
  parameter int NPIX  = 4096,
  parameter int CNT_W = 12,
  parameter int AW    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             int_i,
  input  logic             int_rise_i,
  input  logic             wr_i,
  input  logic [NPIX-1:0]  pulse_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q   [NPIX];
  logic [CNT_W-1:0] cnt_nx  [NPIX];
  logic [CNT_W-1:0] store_q [NPIX];

  always_comb begin
    for (int i = 0; i < NPIX; i++) begin
      if (int_rise_i)
        cnt_nx[i] = CNT_W'(pulse_i[i]);
      else if (int_i && pulse_i[i] && cnt_q[i] != CNT_MAX)
        cnt_nx[i] = cnt_q[i] + 1'b1;
      else
        cnt_nx[i] = cnt_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPIX; i++) begin
        cnt_q[i]   <= '0;
        store_q[i] <= '0;
      end
    end else if (clr_i) begin
      for (int i = 0; i < NPIX; i++) begin
        cnt_q[i]   <= '0;
        store_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NPIX; i++) begin
        cnt_q[i] <= cnt_nx[i];
        // write-cycle strobe lands in the closing frame
        if (wr_i) store_q[i] <= cnt_nx[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= store_q[rd_addr_i];
  end
endmodule

// File: rtl/pfm_scan_ctrl.sv
module pfm_scan_ctrl #(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int RW   = 6,
  parameter int CW   = 6,
  parameter int AW   = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          int_rise_i,
  input  logic          wr_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          tag_valid_o,
  output logic [RW-1:0] tag_row_o,
  output logic [CW-1:0] tag_col_o,
  output logic          tag_last_o,
  output logic          overrun_o
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic          frame_rdy_q, busy_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [AW-1:0] addr_q;
  logic          scan_start, at_last;

  assign scan_start = int_rise_i && frame_rdy_q && !busy_q;
  assign at_last    = (row_q == ROW_LAST) && (col_q == COL_LAST);
  assign rd_en_o    = busy_q;
  assign rd_addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_rdy_q <= 1'b0;
      busy_q      <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      addr_q      <= '0;
      overrun_o   <= 1'b0;
    end else if (clr_i) begin
      frame_rdy_q <= 1'b0;
      busy_q      <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      addr_q      <= '0;
      overrun_o   <= 1'b0;
    end else begin
      if (wr_i)            frame_rdy_q <= 1'b1;
      else if (scan_start) frame_rdy_q <= 1'b0;
      if (wr_i && (busy_q || scan_start)) overrun_o <= 1'b1;
      if (scan_start) begin
        busy_q <= 1'b1;
        row_q  <= '0;
        col_q  <= '0;
        addr_q <= '0;
      end else if (busy_q) begin
        addr_q <= addr_q + 1'b1;
        if (at_last) begin
          busy_q <= 1'b0;
        end else if (col_q == COL_LAST) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  // tags aligned with the registered store read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_valid_o <= 1'b0;
      tag_row_o   <= '0;
      tag_col_o   <= '0;
      tag_last_o  <= 1'b0;
    end else if (clr_i) begin
      tag_valid_o <= 1'b0;
      tag_last_o  <= 1'b0;
    end else begin
      tag_valid_o <= busy_q;
      tag_row_o   <= row_q;
      tag_col_o   <= col_q;
      tag_last_o  <= busy_q && at_last;
    end
  end
endmodule

// File: rtl/pfm_gain_stage.sv
module pfm_gain_stage #(
  parameter int CNT_W  = 12,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 14,
  parameter int RW     = 6,
  parameter int CW     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic [RW-1:0]     row_i,
  input  logic [CW-1:0]     col_i,
  input  logic              last_i,
  input  logic [CNT_W-1:0]  raw_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              corr_en_i,
  output logic              valid_o,
  output logic [RW-1:0]     row_o,
  output logic [CW-1:0]     col_o,
  output logic [CNT_W-1:0]  code_o,
  output logic              eof_o
);
  localparam int PW = CNT_W + GAIN_W + 1;
  localparam logic [CNT_W-1:0] CODE_MAX = '1;

  logic [PW-1:0]    prod, scaled;
  logic [CNT_W-1:0] corr_code;
  logic             last_q;

  always_comb begin
    prod   = PW'(raw_i) * PW'(gain_i) + (PW'(1) << (FRAC - 1));
    scaled = prod >> FRAC;
    if (|scaled[PW-1:CNT_W]) corr_code = CODE_MAX;
    else                     corr_code = scaled[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      row_o   <= '0;
      col_o   <= '0;
      code_o  <= '0;
      last_q  <= 1'b0;
      eof_o   <= 1'b0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
      last_q  <= 1'b0;
      eof_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      row_o   <= row_i;
      col_o   <= col_i;
      code_o  <= corr_en_i ? corr_code : raw_i;
      last_q  <= valid_i && last_i;
      eof_o   <= valid_o && last_q;
    end
  end
endmodule

// File: rtl/pfm_frame_readout.sv
module pfm_frame_readout #(
  parameter int ROWS   = 64,
  parameter int COLS   = 64,
  parameter int CNT_W  = pfm_pkg::CNT_W_DEF,
  parameter int GAIN_W = pfm_pkg::GAIN_W_DEF,
  parameter int FRAC   = pfm_pkg::FRAC_DEF,
  localparam int NPIX  = ROWS * COLS,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              int_i,
  input  logic              wr_i,
  input  logic [NPIX-1:0]   pulse_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              corr_en_i,
  output logic              pix_valid_o,
  output logic [RW-1:0]     pix_row_o,
  output logic [CW-1:0]     pix_col_o,
  output logic [CNT_W-1:0]  pix_code_o,
  output logic              eof_o,
  output logic              overrun_o
);
  localparam int AW = (NPIX > 1) ? $clog2(NPIX) : 1;

  logic             int_q, int_rise;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic [CNT_W-1:0] rd_data;
  logic             tag_valid, tag_last;
  logic [RW-1:0]    tag_row;
  logic [CW-1:0]    tag_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     int_q <= 1'b0;
    else if (clr_i)  int_q <= int_i;
    else             int_q <= int_i;
  end
  assign int_rise = int_i && !int_q && !clr_i;

  pfm_pixel_array #(.NPIX(NPIX), .CNT_W(CNT_W), .AW(AW)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .int_i      (int_i),
    .int_rise_i (int_rise),
    .wr_i       (wr_i),
    .pulse_i    (pulse_i),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data)
  );

  pfm_scan_ctrl #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW), .AW(AW)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .int_rise_i  (int_rise),
    .wr_i        (wr_i),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .tag_valid_o (tag_valid),
    .tag_row_o   (tag_row),
    .tag_col_o   (tag_col),
    .tag_last_o  (tag_last),
    .overrun_o   (overrun_o)
  );

  pfm_gain_stage #(.CNT_W(CNT_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .RW(RW), .CW(CW)) u_gain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .valid_i   (tag_valid),
    .row_i     (tag_row),
    .col_i     (tag_col),
    .last_i    (tag_last),
    .raw_i     (rd_data),
    .gain_i    (gain_i),
    .corr_en_i (corr_en_i),
    .valid_o   (pix_valid_o),
    .row_o     (pix_row_o),
    .col_o     (pix_col_o),
    .code_o    (pix_code_o),
    .eof_o     (eof_o)
  );
endmodule

// File: rtl/pfm_frame_readout_chk.sv
module pfm_frame_readout_chk #(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int RW   = 6,
  parameter int CW   = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          wr_i,
  input logic          pix_valid_o,
  input logic [RW-1:0] pix_row_o,
  input logic [CW-1:0] pix_col_o,
  input logic          eof_o,
  input logic          overrun_o
);
  a_r5_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (int'(pix_row_o) < ROWS) && (int'(pix_col_o) < COLS));

  a_r5_row_major: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && pix_col_o != '0) |->
      $past(pix_valid_o) && $past(pix_row_o) == pix_row_o &&
      $past(pix_col_o) == pix_col_o - CW'(1));

  a_r6_eof_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> $past(pix_valid_o) && int'($past(pix_row_o)) == ROWS - 1 &&
      int'($past(pix_col_o)) == COLS - 1);

  a_r7_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clr_i) |=> overrun_o);

  a_r7_overrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!overrun_o && !wr_i) |=> !overrun_o);

  a_r1_clear_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !overrun_o && !pix_valid_o && !eof_o);
endmodule

bind pfm_frame_readout pfm_frame_readout_chk #(
  .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .wr_i        (wr_i),
  .pix_valid_o (pix_valid_o),
  .pix_row_o   (pix_row_o),
  .pix_col_o   (pix_col_o),
  .eof_o       (eof_o),
  .overrun_o   (overrun_o)
);

// File: tb/pfm_frame_readout_test.sv
module pfm_frame_readout_test;
  localparam int R = 4;
  localparam int C = 4;
  localparam int N = R * C;
  localparam int NV = 5;
  localparam logic [15:0] V_GAIN [NV] = '{16'd16384, 16'd20480, 16'd12000, 16'd3, 16'd40000};
  localparam logic        V_CEN  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int          V_SEED [NV] = '{1, 2, 3, 4, 5};

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, int_s = 1'b0, wr = 1'b0, cen = 1'b0;
  logic [N-1:0] pulse = '0;
  logic [15:0]  gain = 16'd16384;
  logic         valid, eof, ovr;
  logic [1:0]   row, col;
  logic [11:0]  code;

  pfm_frame_readout #(.ROWS(R), .COLS(C)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .int_i(int_s), .wr_i(wr),
    .pulse_i(pulse), .gain_i(gain), .corr_en_i(cen),
    .pix_valid_o(valid), .pix_row_o(row), .pix_col_o(col), .pix_code_o(code),
    .eof_o(eof), .overrun_o(ovr)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int exp_cnt [N];
  int snap [N];
  int prev [N];
  int got [N];
  int ord [N];
  int mon_n, mon_first, mon_last, mon_eof, mon_eofs, start_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (mon_n == 0) mon_first = cyc;
      got[int'(row) * C + int'(col)] = int'(code);
      ord[int'(row) * C + int'(col)] = mon_n;
      mon_n = mon_n + 1;
      mon_last = cyc;
    end
    if (rst_n && eof) begin
      mon_eofs = mon_eofs + 1;
      mon_eof = cyc;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int raw, input int g, input bit ce);
    longint p;
    if (!ce) return raw;
    p = (longint'(raw) * longint'(g) + 8192) >>> 14;
    return (p > 4095) ? 4095 : int'(p);
  endfunction

  task automatic run_window(input int len, input int seed, input bit all_on,
                            input int wr_at, input int clr_at);
    mon_n = 0; mon_eofs = 0; mon_first = -1; mon_last = -1; mon_eof = -1;
    for (int i = 0; i < N; i++) begin got[i] = -1; ord[i] = -1; exp_cnt[i] = 0; end
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      if (t == 0) start_cyc = cyc;
      int_s = 1'b1;
      wr    = (t == wr_at);
      clr   = (t == clr_at);
      for (int i = 0; i < N; i++)
        pulse[i] = all_on || (((t * (i + 1) + seed) % (3 + ((i + seed) % 4))) < 2);
      for (int i = 0; i < N; i++) begin
        if (t == clr_at) exp_cnt[i] = 0;
        else if (pulse[i] && exp_cnt[i] < 4095) exp_cnt[i]++;
      end
      if (t == wr_at) for (int i = 0; i < N; i++) snap[i] = exp_cnt[i];
    end
    @(negedge clk);
    int_s = 1'b0; wr = 1'b0; clr = 1'b0; pulse = '1;  // R2: strobes outside window ignored
    repeat (4) @(negedge clk);
    pulse = '0;
  endtask

  task automatic check_readout(input int g, input bit ce, input string req);
    chk(mon_n == N, "R5 word count", mon_n, N);
    chk(mon_first - start_cyc == 3, "R5 latency", mon_first - start_cyc, 3);
    chk(mon_eofs == 1 && mon_eof == mon_last + 1, "R6 eof position", mon_eof, mon_last + 1);
    for (int i = 0; i < N; i++) begin
      chk(ord[i] == i, "R5 row-major order", ord[i], i);
      chk(got[i] == exp_code(prev[i], g, ce), req, got[i], exp_code(prev[i], g, ce));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid && !ovr && !eof, "R1 reset outputs", {29'd0, valid, ovr, eof}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: first window has nothing to read
    run_window(40, 0, 1'b0, 39, -1);
    chk(mon_n == 0, "R10 no scan without stored frame", mon_n, 0);

    // vector table: each entry reads the previous frame while counting a new one (R11)
    for (int k = 0; k < NV; k++) begin
      prev = snap;
      gain = V_GAIN[k]; cen = V_CEN[k];
      run_window(40, V_SEED[k], 1'b0, 39, -1);
      check_readout(int'(V_GAIN[k]), V_CEN[k], V_CEN[k] ? "R8 corrected code R4 R2" : "R9 raw passthrough");
      chk(!ovr, "R7 no overrun in normal frames", ovr, 0);
    end

    // R3 saturation, then R8 rounding and clipping
    prev = snap; gain = 16'd16384; cen = 1'b1;
    run_window(4100, 0, 1'b1, 4099, -1);
    check_readout(16384, 1'b1, "R8 unity gain");
    prev = snap; gain = 16'd8192; cen = 1'b1;
    run_window(4100, 0, 1'b1, 4099, -1);
    check_readout(8192, 1'b1, "R3 R8 half gain of saturated");
    chk(got[0] == 2048, "R3 saturated 4095 at half gain", got[0], 2048);
    prev = snap; gain = 16'd20480; cen = 1'b1;
    run_window(40, 7, 1'b0, 39, -1);
    chk(got[N-1] == 4095, "R8 clip to 4095", got[N-1], 4095);
    check_readout(20480, 1'b1, "R8 clipped code");
    prev = snap; gain = 16'd1; cen = 1'b0;
    run_window(40, 9, 1'b0, 39, -1);
    check_readout(1, 1'b0, "R9 raw passthrough");

    // R7 overrun: write lands mid-scan
    run_window(40, 3, 1'b0, 5, -1);
    chk(ovr == 1'b1, "R7 overrun raised", ovr, 1);
    prev = snap; gain = 16'd16384; cen = 1'b1;
    run_window(40, 4, 1'b0, 39, -1);
    chk(ovr == 1'b1, "R7 overrun sticky", ovr, 1);
    check_readout(16384, 1'b1, "R4 word stored at early write");

    // R1 clear mid-window
    run_window(40, 6, 1'b1, 39, 10);
    chk(ovr == 1'b0, "R1 clear drops overrun", ovr, 0);
    prev = snap;
    chk(prev[0] == 29, "R1 model count after clear", prev[0], 29);
    run_window(40, 2, 1'b0, 39, -1);
    check_readout(16384, 1'b1, "R1 counters restart at clear");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule